// File: doc/BRIEF.md
# LED Boost Soft-Start and Fault Supervisor

This block sequences start-up and protection for a boost converter that drives a series LED string. It runs from the converter's 1.2 MHz switching clock. When the enable input rises, it raises a digital reference code from zero to the requested target in 32 equal steps. It also asks the power stage for half the normal switch current limit during the opening stretch of start-up. Once the ramp is complete, the reference code follows the target directly.

Four comparator flags arrive as synchronous single-bit inputs: switch-node overvoltage, feedback below half the reference, input undervoltage and over-temperature. Input undervoltage and over-temperature turn the switch off for as long as either is present. While either is present, the start-up timers pause, and the block resumes by itself when the flags clear. An open LED string is detected when the overvoltage flag and the low-feedback flag are both high for a run of consecutive cycles. This fault is latched: the switch stays off and the reference code is zero until the enable input is taken low and raised again.

Top module: `boost_softstart_supervisor`

## Requirements
- R1: While reset is asserted or `enable` is low, `ref_code`, `half_limit`, `switch_en` and `open_fault` are all 0.
- R2: After a rising edge of `enable`, once n active cycles have been counted (n < STEP_CYC*STEPS), `ref_code` equals floor(`target_code` * floor(n/STEP_CYC) / STEPS). The defaults are STEP_CYC=256 and STEPS=32.
- R3: Once STEP_CYC*STEPS active cycles have elapsed, `ref_code` equals `target_code` in the same cycle, including after the target changes, with no new ramp.
- R4: `half_limit` is 1 during the first HALF_CYC active cycles after `enable` rises and 0 afterwards. The default HALF_CYC is 6000, which is 5 ms.
- R5: `open_fault` is set after `sw_ovp` and `fb_low` have both been 1 on OS_CYC consecutive clock edges (default 8). Any edge with either flag at 0 restarts the count.
- R6: While `open_fault` is 1, `switch_en`, `ref_code` and `half_limit` are 0. `open_fault` stays 1, whatever the flags do, until `enable` is low on a clock edge.
- R7: While `vin_uv` is 1, `switch_en` is 0 and the ramp and half-limit timers hold their values. Operation resumes when the flag clears.
- R8: While `over_temp` is 1, `switch_en` is 0 and the ramp and half-limit timers hold their values. Operation resumes when the flag clears.
- R9: When `enable` is high, no fault is latched and neither `vin_uv` nor `over_temp` is 1, `switch_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Converter enable; a rising edge starts soft-start |
| target_code | input | REF_W | Requested reference code |
| sw_ovp | input | 1 | Switch-node overvoltage comparator |
| fb_low | input | 1 | Feedback below half reference comparator |
| vin_uv | input | 1 | Input undervoltage comparator |
| over_temp | input | 1 | Over-temperature comparator |
| ref_code | output | REF_W | Reference code to the error amplifier DAC |
| half_limit | output | 1 | Request for half switch current limit |
| switch_en | output | 1 | Switch gating enable |
| open_fault | output | 1 | Latched open-string fault |

## Verification
On every cycle, the assertions check the following: the switch is off whenever a fault, undervoltage or over-temperature is present; a latched fault holds while the block stays enabled; a fault rises only after both comparator flags were high; and the reference never exceeds the target. Only the bench's scenarios can show the exact staircase values and step timing, the length of the half-limit window, and the pausing of the timers during undervoltage and over-temperature. They also show the exact 8-edge threshold, including a 7-edge run that does not trip, and recovery through an enable toggle.

// File: rtl/boost_softstart_supervisor.sv
module boost_softstart_supervisor #(
  parameter int REF_W    = 8,
  parameter int STEPS    = 32,
  parameter int STEP_CYC = 256,
  parameter int HALF_CYC = 6000,
  parameter int OS_CYC   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [REF_W-1:0] target_code,
  input  logic             sw_ovp,
  input  logic             fb_low,
  input  logic             vin_uv,
  input  logic             over_temp,
  output logic [REF_W-1:0] ref_code,
  output logic             half_limit,
  output logic             switch_en,
  output logic             open_fault
);
  localparam int K_W  = $clog2(STEPS + 1);
  localparam int SH   = $clog2(STEPS);
  localparam int SC_W = $clog2(STEP_CYC);
  localparam int HL_W = $clog2(HALF_CYC + 1);
  localparam int OS_W = $clog2(OS_CYC);
  localparam int P_W  = REF_W + K_W;

  logic            en_q, run, fault;
  logic [K_W-1:0]  step_k;
  logic [SC_W-1:0] step_cnt;
  logic [HL_W-1:0] hl_cnt;
  logic [OS_W-1:0] os_cnt;

  wire active   = run & ~fault;
  wire paused   = vin_uv | over_temp;
  wire ramp_end = (step_k == K_W'(STEPS));
  wire os_cond  = sw_ovp & fb_low;
  wire start    = enable & ~en_q;

  wire [P_W-1:0] prod = {{K_W{1'b0}}, target_code} * {{REF_W{1'b0}}, step_k};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= enable;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
    end else begin
      run <= enable;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_k   <= '0;
      step_cnt <= '0;
    end else if (!enable || start) begin
      step_k   <= '0;
      step_cnt <= '0;
    end else if (active && !paused && !ramp_end) begin
      if (step_cnt == SC_W'(STEP_CYC - 1)) begin
        step_cnt <= '0;
        step_k   <= step_k + 1'b1;
      end else begin
        step_cnt <= step_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 hl_cnt <= '0;
    else if (!enable || start)  hl_cnt <= '0;
    else if (active && !paused && hl_cnt != HL_W'(HALF_CYC))
      hl_cnt <= hl_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      os_cnt <= '0;
      fault  <= 1'b0;
    end else if (!enable || start) begin
      os_cnt <= '0;
      fault  <= 1'b0;
    end else if (active) begin
      if (!os_cond) begin
        os_cnt <= '0;
      end else if (os_cnt == OS_W'(OS_CYC - 1)) begin
        os_cnt <= '0;
        fault  <= 1'b1;
      end else begin
        os_cnt <= os_cnt + 1'b1;
      end
    end
  end

  assign ref_code   = !active  ? '0 :
                      ramp_end ? target_code : prod[SH +: REF_W];
  assign half_limit = active & (hl_cnt != HL_W'(HALF_CYC));
  assign switch_en  = active & enable & ~paused;
  assign open_fault = fault;
endmodule

module boost_softstart_supervisor_chk #(
  parameter int REF_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [REF_W-1:0] target_code,
  input logic             sw_ovp,
  input logic             fb_low,
  input logic             vin_uv,
  input logic             over_temp,
  input logic [REF_W-1:0] ref_code,
  input logic             half_limit,
  input logic             switch_en,
  input logic             open_fault
);
  assert_disable_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (ref_code == '0 && !half_limit && !open_fault));
  assert_ref_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_code <= target_code);
  assert_fault_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_fault) |-> $past(sw_ovp && fb_low));
  assert_fault_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    open_fault |-> (!switch_en && ref_code == '0 && !half_limit));
  assert_fault_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (open_fault && enable) |=> open_fault);
  assert_uv_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vin_uv |-> !switch_en);
  assert_ot_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    over_temp |-> !switch_en);
endmodule

bind boost_softstart_supervisor boost_softstart_supervisor_chk #(.REF_W(REF_W)) u_chk (.*);

// File: tb/tb_boost_softstart_supervisor.sv
module tb_boost_softstart_supervisor;
  localparam int REF_W = 8;
  localparam int STEP_CYC = 256;
  localparam int STEPS = 32;
  localparam int HALF_CYC = 6000;
  localparam int RAMP_CYC = STEP_CYC * STEPS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, ovp = 1'b0, fbl = 1'b0, uv = 1'b0, ot = 1'b0;
  logic [REF_W-1:0] tgt = '0;
  logic [REF_W-1:0] ref_code;
  logic half_limit, switch_en, open_fault;

  int checks = 0, errors = 0;
  int act = 0, os_run = 0;
  bit m_run = 0, m_fault = 0, m_prev = 0;

  always #5 clk = ~clk;

  boost_softstart_supervisor dut (
    .clk(clk), .rst_n(rst_n), .enable(en), .target_code(tgt),
    .sw_ovp(ovp), .fb_low(fbl), .vin_uv(uv), .over_temp(ot),
    .ref_code(ref_code), .half_limit(half_limit),
    .switch_en(switch_en), .open_fault(open_fault));

  function automatic int exp_ref(int t, int a, bit live);
    if (!live) return 0;
    if (a >= RAMP_CYC) return t;
    return (t * (a / STEP_CYC)) / STEPS;
  endfunction

  task automatic chk(string req, int act_v, int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act_v, exp_v, $time);
    end
  endtask

  task automatic tick();
    bit live;
    string rq;
    @(posedge clk);
    if (!rst_n || !en) begin
      m_run = 0; m_fault = 0; act = 0; os_run = 0;
    end else if (!m_prev) begin
      m_run = 1; m_fault = 0; act = 0; os_run = 0;
    end else if (!m_fault) begin
      if (ovp && fbl) begin
        os_run++;
        if (os_run == 8) begin m_fault = 1; os_run = 0; end
      end else os_run = 0;
      if (!uv && !ot) act++;
    end
    m_prev = rst_n ? en : 1'b0;
    #1;
    live = m_run && !m_fault;
    rq = !m_run ? "R1" : m_fault ? "R6" : (act >= RAMP_CYC) ? "R3" : "R2";
    chk(rq, ref_code, exp_ref(tgt, act, live));
    rq = !m_run ? "R1" : m_fault ? "R6" : "R4";
    chk(rq, half_limit, live && act < HALF_CYC);
    rq = !m_run ? "R1" : m_fault ? "R6" : uv ? "R7" : ot ? "R8" : "R9";
    chk(rq, switch_en, live && !uv && !ot);
    chk(m_run ? "R5" : "R1", open_fault, m_fault);
  endtask

  task automatic run_n(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #1_900_000;
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    run_n(4);
    rst_n = 1'b1;
    run_n(4);
    en = 1'b1; tgt = 8'd200;
    run_n(1000);
    uv = 1'b1; run_n(50); uv = 1'b0;
    run_n(2000);
    ot = 1'b1; run_n(30); ot = 1'b0;
    run_n(6000);
    tgt = 8'd57; run_n(5);
    tgt = 8'd255; run_n(5);
    ovp = 1'b1; fbl = 1'b1; run_n(7);
    fbl = 1'b0; run_n(1);
    fbl = 1'b1; run_n(8);
    ovp = 1'b0; fbl = 1'b0; run_n(20);
    en = 1'b0; run_n(10);
    en = 1'b1; tgt = 8'd31; run_n(600);
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(0, 199) == 0) uv = ~uv;
      if ($urandom_range(0, 299) == 0) ot = ~ot;
      if ($urandom_range(0, 99) == 0) ovp = ~ovp;
      if ($urandom_range(0, 99) == 0) fbl = ~fbl;
      if ($urandom_range(0, 499) == 0) tgt = REF_W'($urandom);
      if ($urandom_range(0, 2999) == 0) en = ~en;
      tick();
    end
    en = 1'b0; run_n(3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule